// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is a short first-in first-out queue placed between the instruction fetch stage and the operand fetch stage of a three-stage pipeline. Each slot holds one fetched instruction word together with the address it was fetched from. When an instruction in execute takes several cycles, for example a multiply, divide or floating-point operation, operand fetch stalls. Only one instruction can be in execute at a time. While operand fetch is stalled, fetch keeps running and the returned words collect in the queue until it is full.

The fetch side gets a request signal that tells the instruction memory side whether a returned word will be taken in the current cycle. The decode side sees a valid/ready pair that always shows the oldest word held. When the queue is empty, a word arriving from memory goes straight to decode in the same cycle. A taken branch raises the flush input. This empties every slot in one cycle and drops any word returning in that cycle. Storage is a shift register: the head is always slot 0, and slots move down by one when the head leaves.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset the queue is empty: `dec_vld_o` is 0 and `fetch_req_o` is 1.
- R2: When the queue is empty and `fill_vld_i` is 1 with no flush, `dec_vld_o` is 1 in that same cycle and `dec_instr_o`/`dec_pc_o` equal `fill_instr_i`/`fill_pc_i`. If `dec_rdy_i` is also 1, the word is consumed and not stored.
- R3: The queue holds at most four words. `fetch_req_o` is 0 exactly when four words are held, no word leaves towards decode in that cycle, and there is no flush.
- R4: Words reach decode in the order they were accepted. The head is always the oldest word held.
- R5: In a cycle with `flush_i` at 1, `dec_vld_o` is 0, `fetch_req_o` is 1, and no word is taken from either side. In the next cycle the queue is empty, and a word returning during the flush cycle is lost.
- R6: A word offered while `fetch_req_o` is 0 is ignored. It never reaches decode.
- R7: When the queue is full, a word arriving in the same cycle as a word leaving for decode is accepted, and the queue stays full with order kept.
- R8: While decode holds `dec_rdy_i` at 0 and there is no flush, the presented word stays on `dec_vld_o`, `dec_instr_o` and `dec_pc_o` unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Taken branch: empty the queue and drop the current return |
| fetch_req_o | output | 1 | Fetch side may deliver a word this cycle |
| fill_vld_i | input | 1 | A fetched word is returning this cycle |
| fill_instr_i | input | 32 | Returned instruction word |
| fill_pc_i | input | 32 | Address of the returned word |
| dec_vld_o | output | 1 | Head word is valid for decode |
| dec_instr_o | output | 32 | Head instruction word |
| dec_pc_o | output | 32 | Head instruction address |
| dec_rdy_i | input | 1 | Decode takes the head word this cycle |

## Verification
`dec_vld_o`, `dec_instr_o`, `dec_pc_o` and `fetch_req_o` are combinational in the current inputs and the stored state. They are due in the same cycle as the stimulus: the bypass word, the full-and-stalled drop of the request, and the quiet output during a flush all appear before the next edge. Occupancy changes, such as the emptying after a flush or a word stored behind a stalled head, show up one clock edge later. The bench drives inputs just after the falling edge and compares 1 ns later against a queue-based model. It updates that model only when it moves to the next cycle, so every value is sampled in the cycle it is due.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

   // Kind of occupancy change in one cycle
   typedef enum logic [1:0] {
      IPQ_HOLD = 2'b00,
      IPQ_POP  = 2'b01,
      IPQ_PUSH = 2'b10,
      IPQ_BOTH = 2'b11
   } ipq_op_e;

   function automatic ipq_op_e ipq_op(input logic push, input logic pop);
      return ipq_op_e'({push, pop});
   endfunction

endpackage

// File: rtl/ipq_slot.sv
module ipq_slot #(
   parameter int unsigned W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         shift_en_i,
   input  logic         load_en_i,
   input  logic [W-1:0] load_d_i,
   input  logic [W-1:0] next_d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_r <= '0;
      end else if (load_en_i) begin
         q_r <= load_d_i;
      end else if (shift_en_i) begin
         q_r <= next_d_i;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/ipq_ctrl.sv
module ipq_ctrl
   import ipq_pkg::*;
#(
   parameter int unsigned DEPTH     = 4,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             in_vld_i,
   input  logic             out_rdy_i,
   output logic             fetch_req_o,
   output logic             out_vld_o,
   output logic             bypass_o,
   output logic             shift_en_o,
   output logic [DEPTH-1:0] load_vec_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_r;
   logic [CNT_W-1:0] cnt_nx;
   logic [CNT_W-1:0] wr_idx;
   logic             empty;
   logic             full;
   logic             bypass_avail;
   logic             pop;
   logic             pop_st;
   logic             take_in;
   logic             push;
   ipq_op_e          op;

   assign empty = (cnt_r == '0);
   assign full  = (cnt_r == CNT_W'(DEPTH));

   generate
      if (BYPASS_EN) begin : g_byp
         assign bypass_avail = empty && in_vld_i;
      end else begin : g_nobyp
         assign bypass_avail = 1'b0;
      end
   endgenerate

   assign out_vld_o   = !flush_i && (!empty || bypass_avail);
   assign pop         = out_vld_o && out_rdy_i;
   assign pop_st      = pop && !empty;
   assign fetch_req_o = flush_i || !(full && !pop);
   assign take_in     = in_vld_i && fetch_req_o && !flush_i;
   assign push        = take_in && !(empty && pop);
   assign bypass_o    = empty;
   assign shift_en_o  = pop_st;
   assign op          = ipq_op(push, pop_st);
   assign wr_idx      = pop_st ? (cnt_r - CNT_W'(1)) : cnt_r;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ld
         assign load_vec_o[i] = push && (wr_idx == CNT_W'(i));
      end
   endgenerate

   always_comb begin
      cnt_nx = cnt_r;
      if (flush_i) begin
         cnt_nx = '0;
      end else begin
         unique case (op)
            IPQ_PUSH: cnt_nx = cnt_r + CNT_W'(1);
            IPQ_POP:  cnt_nx = cnt_r - CNT_W'(1);
            default:  cnt_nx = cnt_r;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_r <= '0;
      end else begin
         cnt_r <= cnt_nx;
      end
   end

   assign cnt_o = cnt_r;

endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue #(
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned PC_W      = 32,
   parameter int unsigned DEPTH     = 4,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               flush_i,
   output logic               fetch_req_o,
   input  logic               fill_vld_i,
   input  logic [INSTR_W-1:0] fill_instr_i,
   input  logic [PC_W-1:0]    fill_pc_i,
   output logic               dec_vld_o,
   output logic [INSTR_W-1:0] dec_instr_o,
   output logic [PC_W-1:0]    dec_pc_o,
   input  logic               dec_rdy_i
);

   localparam int unsigned ENT_W = INSTR_W + PC_W;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("instr_prefetch_queue: DEPTH must be at least 2");
      end
      if (INSTR_W < 1 || PC_W < 1) begin : g_bad_width
         $error("instr_prefetch_queue: widths must be positive");
      end
   endgenerate

   logic [DEPTH-1:0] load_vec;
   logic             shift_en;
   logic             is_empty;
   logic [CNT_W-1:0] occ_cnt;
   logic [ENT_W-1:0] fill_ent;
   logic [ENT_W-1:0] slot_q [DEPTH];
   logic [ENT_W-1:0] head_ent;

   assign fill_ent = {fill_pc_i, fill_instr_i};

   ipq_ctrl #(
      .DEPTH    (DEPTH),
      .BYPASS_EN(BYPASS_EN)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .in_vld_i   (fill_vld_i),
      .out_rdy_i  (dec_rdy_i),
      .fetch_req_o(fetch_req_o),
      .out_vld_o  (dec_vld_o),
      .bypass_o   (is_empty),
      .shift_en_o (shift_en),
      .load_vec_o (load_vec),
      .cnt_o      (occ_cnt)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [ENT_W-1:0] nxt;
         if (i == DEPTH - 1) begin : g_tail
            assign nxt = '0;
         end else begin : g_mid
            assign nxt = slot_q[i+1];
         end
         ipq_slot #(.W(ENT_W)) u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .shift_en_i(shift_en),
            .load_en_i (load_vec[i]),
            .load_d_i  (fill_ent),
            .next_d_i  (nxt),
            .q_o       (slot_q[i])
         );
      end
   endgenerate

   generate
      if (BYPASS_EN) begin : g_out_byp
         assign head_ent = is_empty ? fill_ent : slot_q[0];
      end else begin : g_out_reg
         assign head_ent = slot_q[0];
      end
   endgenerate

   assign dec_instr_o = head_ent[INSTR_W-1:0];
   assign dec_pc_o    = head_ent[ENT_W-1:INSTR_W];

endmodule

// File: rtl/instr_prefetch_queue_chk.sv
module instr_prefetch_queue_chk #(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned PC_W    = 32,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned CNT_W   = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               flush_i,
   input logic               fetch_req_o,
   input logic               fill_vld_i,
   input logic [INSTR_W-1:0] fill_instr_i,
   input logic               dec_vld_o,
   input logic               dec_rdy_i,
   input logic [INSTR_W-1:0] dec_instr_o,
   input logic [PC_W-1:0]    dec_pc_o,
   input logic [CNT_W-1:0]   occ
);

   assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ <= CNT_W'(DEPTH));

   assert_full_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ == CNT_W'(DEPTH) && !dec_rdy_i && !flush_i) |-> !fetch_req_o);

   assert_empty_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ == '0 && fill_vld_i && !flush_i) |-> (dec_vld_o && dec_instr_o == fill_instr_i));

   assert_flush_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (occ == '0));

   assert_flush_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |-> !dec_vld_o);

   assert_ignored_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fetch_req_o && !flush_i) |=> (occ == $past(occ)));

   assert_hold_head_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_vld_o && !dec_rdy_i && !flush_i) |=>
         (flush_i || (dec_vld_o && $stable(dec_instr_o) && $stable(dec_pc_o))));

endmodule

bind instr_prefetch_queue instr_prefetch_queue_chk #(
   .INSTR_W(INSTR_W),
   .PC_W   (PC_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .flush_i     (flush_i),
   .fetch_req_o (fetch_req_o),
   .fill_vld_i  (fill_vld_i),
   .fill_instr_i(fill_instr_i),
   .dec_vld_o   (dec_vld_o),
   .dec_rdy_i   (dec_rdy_i),
   .dec_instr_o (dec_instr_o),
   .dec_pc_o    (dec_pc_o),
   .occ         (occ_cnt)
);

// File: tb/instr_prefetch_queue_tb_top.sv
module instr_prefetch_queue_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        fill_vld = 1'b0;
   logic [31:0] fill_instr = '0;
   logic [31:0] fill_pc = '0;
   logic        dec_rdy = 1'b0;
   logic        fetch_req;
   logic        dec_vld;
   logic [31:0] dec_instr;
   logic [31:0] dec_pc;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [63:0] mq[$];
   logic [31:0] npc = 32'h0000_1000;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   instr_prefetch_queue dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .flush_i     (flush),
      .fetch_req_o (fetch_req),
      .fill_vld_i  (fill_vld),
      .fill_instr_i(fill_instr),
      .fill_pc_i   (fill_pc),
      .dec_vld_o   (dec_vld),
      .dec_instr_o (dec_instr),
      .dec_pc_o    (dec_pc),
      .dec_rdy_i   (dec_rdy)
   );

   task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
      end
   endtask

   // one cycle: drive, compare against the model, advance the model
   task automatic step(input logic fv, input logic fl, input logic rdy, input string tag);
      logic        e_vld, e_req, taken, acc;
      logic [63:0] e_head;
      fill_vld   = fv;
      flush      = fl;
      dec_rdy    = rdy;
      fill_pc    = npc;
      fill_instr = npc ^ 32'h5A3C_0000;
      #1;
      e_vld  = !fl && (mq.size() != 0 || fv);
      e_head = (mq.size() != 0) ? mq[0] : {fill_pc, fill_instr};
      taken  = e_vld && rdy;
      e_req  = fl || !(mq.size() == 4 && !taken);
      chk(tag, "dec_vld", {31'd0, dec_vld}, {31'd0, e_vld});
      chk(tag, "fetch_req", {31'd0, fetch_req}, {31'd0, e_req});
      if (e_vld) begin
         chk(tag, "dec_instr", dec_instr, e_head[31:0]);
         chk(tag, "dec_pc", dec_pc, e_head[63:32]);
      end
      if (fl) begin
         mq.delete();
         npc = npc + 32'h100;
      end else begin
         acc = fv && e_req;
         if (acc) begin
            mq.push_back({fill_pc, fill_instr});
            npc = npc + 32'd4;
         end
         if (taken) void'(mq.pop_front());
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset
      step(0, 0, 0, "R1");
      step(0, 0, 1, "R1");
      // R2: bypass stream, decode always ready
      for (int i = 0; i < 6; i++) step(1, 0, 1, "R2");
      // R2/R8: empty, stalled decode, word stored and held
      step(1, 0, 0, "R2");
      step(0, 0, 0, "R8");
      // R3/R6: keep offering while stalled; beyond four words ignored
      for (int i = 0; i < 6; i++) step(1, 0, 0, "R3");
      step(1, 0, 0, "R6");
      step(0, 0, 0, "R8");
      // R7: full, simultaneous leave and arrive
      for (int i = 0; i < 5; i++) step(1, 0, 1, "R7");
      // R4: drain in order
      for (int i = 0; i < 5; i++) step(0, 0, 1, "R4");
      // R5: fill then flush with a returning word
      for (int i = 0; i < 3; i++) step(1, 0, 0, "R5");
      step(1, 1, 1, "R5");
      step(0, 0, 1, "R5");
      step(1, 0, 0, "R5");
      step(0, 0, 0, "R5");
      // R5: flush when full
      for (int i = 0; i < 5; i++) step(1, 0, 0, "R5");
      step(1, 1, 0, "R5");
      step(0, 0, 1, "R5");
      // R4: mixed traffic
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[3], (lfsr[7:2] == 6'h2A), lfsr[5] | lfsr[9], "R4");
      end
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule